// File: doc/BRIEF.md
# Two-Bank Interleaved DRAM Sequencer

This block connects one CPU bus port to two DRAM banks and turns each CPU read or write into a strobe sequence for one bank. The least significant word-address bit picks the bank. The remaining bits split into a column field and a row field. Both fields go out on that bank's multiplexed address pins: the row comes first, strobed by the row strobe, and the column follows under the column strobe. When the access finishes, the sequencer raises a single-cycle ready pulse back to the CPU.

A bank whose row strobe has just been released needs a precharge interval before it can take a new row. Each bank therefore keeps its own precharge countdown. If the next access goes to the other bank, that bank's countdown has long expired, so the access starts at once and the precharge is hidden. If the next access goes to the same bank, the request is held off with ready low until that bank's countdown allows a new row strobe. Row-to-column delay, column strobe width and precharge interval are parameters counted in clock cycles, each at least 1.

Top module: `ileave_dram_seq`

## Requirements
- R1: The bank is `reqAddr[0]`. The column is `reqAddr[COL_W:1]`. The row is `reqAddr[ADDR_W-1:COL_W+1]`, where `ADDR_W = 1 + COL_W + ROW_W`. Only the selected bank's strobes move.
- R2: When a bank's `rasN` falls, its address pins carry the row, zero-extended. `rasN` stays low with `casN` high for exactly `T_RAC` cycles before `casN` falls.
- R3: While `casN` of a bank is low, which lasts exactly `T_CAS` cycles, its address pins carry the column and `rasN` stays low. `weN` of that bank is low in every one of those cycles for a write and high for a read. `weN` is never low while `casN` is high.
- R4: `ready` is high for exactly one cycle, in the last cycle of the column strobe. A request first presented in cycle c to a free bank gets `ready` in cycle c + T_RAC + T_CAS.
- R5: After an access, a bank's `rasN` stays high for at least `T_RP` cycles before it falls again.
- R6: The CPU holds the request inputs stable until `ready`. A new request is taken in the cycle after a `ready`, with no extra turnaround cycle.
- R7: When consecutive accesses go to different banks, the second one incurs no stall. Its `ready` comes T_RAC + T_CAS cycles after it is presented.
- R8: A request presented in the cycle right after `ready` to the same bank is stalled `T_RP - 1` cycles. Its `rasN` falls after exactly `T_RP` high cycles.
- R9: On a read, `rdData` in the `ready` cycle equals the selected bank's `memRdata` input, which returns the word last written to that address.
- R10: During and right after reset, all strobes (`rasN`, `casN`, `weN`) are high and `ready` is low. At most one bank has `rasN` low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | CPU request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | CPU word address |
| wrData | input | DATA_W | CPU write data |
| rdData | output | DATA_W | Read data, valid with ready |
| ready | output | 1 | One-cycle completion pulse |
| rasN | output | 2 | Row strobe per bank, active low |
| casN | output | 2 | Column strobe per bank, active low |
| weN | output | 2 | Write enable per bank, active low |
| memAddrA | output | MUX_W | Multiplexed address, bank 0 |
| memAddrB | output | MUX_W | Multiplexed address, bank 1 |
| memWdata | output | DATA_W | Write data to both banks |
| memRdataA | input | DATA_W | Read data from bank 0 |
| memRdataB | input | DATA_W | Read data from bank 1 |

## Verification
Two things can fall in the same cycle. One is the end of a bank's precharge countdown. The other is the sequencer's decision to accept a new request for that same bank, which it takes while the counter is at its last step.

The bench provokes this by issuing same-bank requests in the cycle right after `ready`. It also places requests after idle gaps of varying length, so that each bank's countdown is caught at different points. A behavioural bank model counts the cycles that `rasN` is high and the cycles from row strobe to column strobe. In parallel, a separately computed schedule predicts the exact cycle of every `ready` pulse and is compared against the output on every clock. A sequencer that starts one cycle early violates the bank's precharge. One that starts one cycle late misses the predicted `ready`.

// File: rtl/idram_pkg.sv
package idram_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ROW  = 2'd1,
    S_COL  = 2'd2
  } seqState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic load;      // latch the request, start a row strobe
    logic rowPhase;  // row address phase
    logic colPhase;  // column strobe phase
    logic startPre;  // last column cycle, start precharge countdown
  } seqStrobe_t;

endpackage

// File: rtl/idram_ctrl.sv
module idram_ctrl
  import idram_pkg::*;
#(
  parameter int T_RAC = 2,
  parameter int T_CAS = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       bankReady,
  output seqStrobe_t strobe,
  output logic       ready
);

  localparam int MAXT = (T_RAC > T_CAS) ? T_RAC : T_CAS;
  localparam int CW   = $clog2(MAXT + 1);

  seqState_t state;
  logic [CW-1:0] cnt;
  logic lastCnt;

  assign lastCnt = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (reqValid && bankReady) begin
            state <= S_ROW;
            cnt   <= CW'(T_RAC - 1);
          end
        end
        S_ROW: begin
          if (lastCnt) begin
            state <= S_COL;
            cnt   <= CW'(T_CAS - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_COL: begin
          if (lastCnt) begin
            state <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load     = (state == S_IDLE) && reqValid && bankReady;
    strobe.rowPhase = (state == S_ROW);
    strobe.colPhase = (state == S_COL);
    strobe.startPre = (state == S_COL) && lastCnt;
  end

  assign ready = strobe.startPre;

endmodule

// File: rtl/idram_path.sv
module idram_path
  import idram_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 3,
  parameter int DATA_W = 16,
  parameter int T_RP   = 3,
  parameter int NBANK  = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [COL_W+ROW_W:0]        reqAddr,
  input  logic                        reqWrite,
  input  logic [DATA_W-1:0]           wrData,
  input  seqStrobe_t                  strobe,
  input  logic [NBANK-1:0][DATA_W-1:0] memRdata,
  output logic                        bankReady,
  output logic [DATA_W-1:0]           rdData,
  output logic [NBANK-1:0]            rasN,
  output logic [NBANK-1:0]            casN,
  output logic [NBANK-1:0]            weN,
  output logic [NBANK-1:0][((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] memAddr,
  output logic [DATA_W-1:0]           memWdata
);

  localparam int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int PW    = $clog2(T_RP + 1);

  logic              curBank;
  logic [ROW_W-1:0]  curRow;
  logic [COL_W-1:0]  curCol;
  logic              curWrite;
  logic [DATA_W-1:0] curData;
  logic [NBANK-1:0][PW-1:0] preCnt;
  logic              reqBank;

  assign reqBank = reqAddr[0];

  // a bank may start a row strobe when its countdown is at its last step
  assign bankReady = (preCnt[reqBank] <= PW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curBank  <= 1'b0;
      curRow   <= '0;
      curCol   <= '0;
      curWrite <= 1'b0;
      curData  <= '0;
    end else if (strobe.load) begin
      curBank  <= reqBank;
      curCol   <= reqAddr[COL_W:1];
      curRow   <= reqAddr[COL_W+ROW_W:COL_W+1];
      curWrite <= reqWrite;
      curData  <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (strobe.startPre && (curBank == b[0])) begin
          preCnt[b] <= PW'(T_RP);
        end else if (preCnt[b] != '0) begin
          preCnt[b] <= preCnt[b] - 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      logic sel;
      sel        = (curBank == b[0]);
      rasN[b]    = !(sel && (strobe.rowPhase || strobe.colPhase));
      casN[b]    = !(sel && strobe.colPhase);
      weN[b]     = !(sel && strobe.colPhase && curWrite);
      memAddr[b] = strobe.colPhase ? MUX_W'(curCol) : MUX_W'(curRow);
    end
  end

  assign memWdata = curData;
  assign rdData   = memRdata[curBank];

endmodule

// File: rtl/ileave_dram_seq.sv
module ileave_dram_seq
  import idram_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 3,
  parameter int DATA_W = 16,
  parameter int T_RAC  = 2,
  parameter int T_CAS  = 1,
  parameter int T_RP   = 3,
  localparam int ADDR_W = 1 + COL_W + ROW_W,
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              ready,
  output logic [1:0]        rasN,
  output logic [1:0]        casN,
  output logic [1:0]        weN,
  output logic [MUX_W-1:0]  memAddrA,
  output logic [MUX_W-1:0]  memAddrB,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdataA,
  input  logic [DATA_W-1:0] memRdataB
);

  seqStrobe_t strobe;
  logic bankReady;
  logic [1:0][MUX_W-1:0]  memAddr;
  logic [1:0][DATA_W-1:0] memRdata;

  assign memRdata = {memRdataB, memRdataA};
  assign memAddrA = memAddr[0];
  assign memAddrB = memAddr[1];

  idram_ctrl #(
    .T_RAC(T_RAC),
    .T_CAS(T_CAS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .bankReady(bankReady),
    .strobe   (strobe),
    .ready    (ready)
  );

  idram_path #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .DATA_W(DATA_W),
    .T_RP  (T_RP),
    .NBANK (2)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .wrData   (wrData),
    .strobe   (strobe),
    .memRdata (memRdata),
    .bankReady(bankReady),
    .rdData   (rdData),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

endmodule

// File: rtl/idram_chk.sv
module idram_chk #(
  parameter int T_RAC = 2,
  parameter int T_CAS = 1,
  parameter int T_RP  = 3
) (
  input logic       clk,
  input logic       rstN,
  input logic       ready,
  input logic [1:0] rasN,
  input logic [1:0] casN,
  input logic [1:0] weN
);

  logic [1:0][15:0] hiCnt;  // consecutive cycles with rasN high
  logic [1:0][15:0] loCnt;  // consecutive cycles with rasN low, casN high
  logic [1:0][15:0] casCnt; // consecutive cycles with casN low

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++) begin
        hiCnt[b]  <= 16'(T_RP);
        loCnt[b]  <= '0;
        casCnt[b] <= '0;
      end
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (rasN[b]) hiCnt[b] <= (hiCnt[b] == 16'hFFFF) ? hiCnt[b] : hiCnt[b] + 1'b1;
        else         hiCnt[b] <= '0;
        if (!rasN[b] && casN[b]) loCnt[b] <= (loCnt[b] == 16'hFFFF) ? loCnt[b] : loCnt[b] + 1'b1;
        else                     loCnt[b] <= '0;
        if (!casN[b]) casCnt[b] <= (casCnt[b] == 16'hFFFF) ? casCnt[b] : casCnt[b] + 1'b1;
        else          casCnt[b] <= '0;
      end
    end
  end

  // R4: ready lasts a single cycle
  a_r4_ready_single: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> !ready);

  // R10: at most one row strobe active
  a_r10_one_ras: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~rasN));

  // R4: ready coincides with an active column strobe
  a_r4_ready_in_cas: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (casN != 2'b11));

  for (genvar b = 0; b < 2; b++) begin : g_bank
    // R5: precharge interval respected
    a_r5_precharge: assert property (@(posedge clk) disable iff (!rstN)
      $fell(rasN[b]) |-> (hiCnt[b] >= 16'(T_RP)));
    // R2: row held T_RAC cycles before column strobe
    a_r2_rac: assert property (@(posedge clk) disable iff (!rstN)
      $fell(casN[b]) |-> (loCnt[b] == 16'(T_RAC)));
    // R3: column strobe only inside row strobe
    a_r3_cas_in_ras: assert property (@(posedge clk) disable iff (!rstN)
      !casN[b] |-> !rasN[b]);
    // R3: write enable only inside column strobe
    a_r3_we_in_cas: assert property (@(posedge clk) disable iff (!rstN)
      !weN[b] |-> !casN[b]);
    // R3: column strobe lasts T_CAS cycles
    a_r3_cas_width: assert property (@(posedge clk) disable iff (!rstN)
      $rose(casN[b]) |-> (casCnt[b] == 16'(T_CAS)));
  end

endmodule

bind ileave_dram_seq idram_chk #(
  .T_RAC(T_RAC),
  .T_CAS(T_CAS),
  .T_RP (T_RP)
) u_chk (
  .clk  (clk),
  .rstN (rstN),
  .ready(ready),
  .rasN (rasN),
  .casN (casN),
  .weN  (weN)
);

// File: tb/sim_ileave_dram_seq.sv
module sim_ileave_dram_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W  = 4;
  localparam int COL_W  = 3;
  localparam int DATA_W = 16;
  localparam int T_RAC  = 2;
  localparam int T_CAS  = 1;
  localparam int T_RP   = 3;
  localparam int ADDR_W = 1 + COL_W + ROW_W;
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int WORDS  = 1 << (ROW_W + COL_W);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic ready;
  logic [1:0] rasN, casN, weN;
  logic [MUX_W-1:0] memAddrA, memAddrB;
  logic [DATA_W-1:0] memWdata, memRdataA, memRdataB;

  always #(CLK_PERIOD/2) clk = ~clk;

  ileave_dram_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_RAC(T_RAC), .T_CAS(T_CAS), .T_RP(T_RP)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .wrData(wrData), .rdData(rdData), .ready(ready),
    .rasN(rasN), .casN(casN), .weN(weN), .memAddrA(memAddrA),
    .memAddrB(memAddrB), .memWdata(memWdata), .memRdataA(memRdataA),
    .memRdataB(memRdataB)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s cyc=%0d act=%0h exp=%0h", tag, what, cyc, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // expected schedule
  int expReady = -1;
  int freeAt[2] = '{0, 0};
  int expBank = 0;
  int expRow = 0;
  int expCol = 0;
  bit isRead = 0;
  logic [DATA_W-1:0] expRd = '0;
  string curTag = "R4";
  logic [DATA_W-1:0] shadow [WORDS*2];

  // behavioural bank model
  logic [DATA_W-1:0] bmem [2][WORDS];
  logic [ROW_W-1:0] openRow [2];
  int hi[2] = '{1000, 1000};
  int lo[2] = '{0, 0};
  logic prevRas[2] = '{1'b1, 1'b1};
  logic prevCas[2] = '{1'b1, 1'b1};
  logic [MUX_W-1:0] maddr [2];

  assign maddr[0] = memAddrA;
  assign maddr[1] = memAddrB;
  assign memRdataA = !casN[0] ? bmem[0][{openRow[0], memAddrA[COL_W-1:0]}] : '0;
  assign memRdataB = !casN[1] ? bmem[1][{openRow[1], memAddrB[COL_W-1:0]}] : '0;

  initial begin
    for (int i = 0; i < WORDS * 2; i++) shadow[i] = '0;
    for (int b = 0; b < 2; b++) begin
      openRow[b] = '0;
      for (int i = 0; i < WORDS; i++) bmem[b][i] = '0;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      if (rasN == 2'b00) chk(0, "R10", "both banks open", rasN, 2'b11);
      for (int b = 0; b < 2; b++) begin
        if (!rasN[b] && prevRas[b]) begin
          chk(hi[b] >= T_RP, "R5", "precharge cycles", hi[b], T_RP);
          chk(b == expBank, "R1", "bank select", b, expBank);
          chk(maddr[b] == MUX_W'(expRow), "R2", "row address", maddr[b], expRow);
          openRow[b] = maddr[b][ROW_W-1:0];
        end
        if (!casN[b]) begin
          chk(!rasN[b], "R3", "cas outside ras", rasN[b], 0);
          chk(maddr[b] == MUX_W'(expCol), "R3", "column address", maddr[b], expCol);
          chk(weN[b] == isRead, "R3", "write enable", weN[b], isRead);
          if (prevCas[b]) chk(lo[b] == T_RAC, "R2", "row to column delay", lo[b], T_RAC);
          if (!weN[b]) bmem[b][{openRow[b], maddr[b][COL_W-1:0]}] = memWdata;
        end else if (!weN[b]) begin
          chk(0, "R3", "we without cas", weN[b], 1);
        end
        hi[b] = rasN[b] ? hi[b] + 1 : 0;
        lo[b] = (!rasN[b] && casN[b]) ? lo[b] + 1 : 0;
        prevRas[b] = rasN[b];
        prevCas[b] = casN[b];
      end
      // ready schedule compared on every clock
      chk(ready === (cyc == expReady), curTag, "ready timing", ready, cyc == expReady);
      if (ready && isRead) chk(rdData == expRd, "R9", "read data", rdData, expRd);
    end
  end

  task automatic doOp(input bit wr, input int addr, input string tag);
    int b;
    int start;
    @(posedge clk); #1;
    b = addr & 1;
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = ADDR_W'(addr);
    wrData   = DATA_W'(16'hA500 ^ (addr * 37));
    expBank  = b;
    expCol   = (addr >> 1) & ((1 << COL_W) - 1);
    expRow   = addr >> (1 + COL_W);
    isRead   = !wr;
    expRd    = shadow[addr];
    curTag   = tag;
    start    = (cyc > freeAt[b]) ? cyc : freeAt[b];
    expReady = start + T_RAC + T_CAS;
    do @(negedge clk); while (ready !== 1'b1 && cyc <= expReady + 2);
    if (wr) shadow[addr] = wrData;
    freeAt[b] = expReady + T_RP;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      reqValid = 1'b0;
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL R4 watchdog expired act=0 exp=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(rasN == 2'b11 && casN == 2'b11 && weN == 2'b11 && !ready, "R10", "reset state",
        {ready, weN, casN, rasN}, 7'h3F);
    // R7: alternating banks, R6 back to back
    for (int a = 0; a < 16; a++) doOp(1, a, "R7");
    // R8: same bank back to back
    for (int a = 32; a < 40; a += 2) doOp(1, a, "R8");
    // R1: extreme rows and columns
    doOp(1, 255, "R1");
    doOp(1, 254, "R1");
    doOp(1, 128, "R1");
    idle(4);
    // R9: read back with alternating banks
    for (int a = 0; a < 16; a++) doOp(0, a, "R9");
    // R8: same bank reads
    doOp(0, 32, "R8");
    doOp(0, 34, "R8");
    idle(1);
    doOp(0, 36, "R8");
    idle(2);
    doOp(0, 38, "R8");
    idle(6);
    // R4: request to a long-idle bank
    doOp(0, 255, "R4");
    doOp(0, 254, "R6");
    doOp(0, 128, "R6");
    doOp(0, 129, "R7");
    idle(8);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule